// File: doc/BRIEF.md
# Printer Port Data and Strobe Output

This block drives the host side of a Centronics-style parallel printer port. A byte written at bus address 0 goes into an output data latch that drives the eight data lines. A read from the same address does not return that byte. It returns a status byte built from five printer status lines, each passed through a two-flop synchronizer. Bus address 1 holds a four-bit control register, which can be written and read back.

The control register chooses how the strobe is produced. In automatic mode, each data write fires a strobe pulse with a fixed width. Two widths are available, a long 6.4 µs pulse and a short 1.6 µs pulse. Each width is converted to clock cycles from a clock-frequency parameter and rounded to the nearest whole cycle. In manual mode, software drives the strobe level directly through a control bit. A further control bit drives the printer's input-prime line. All outputs are registered, and reset is synchronous and active high.

Top module: `pport_strobe_if`

## Requirements
- R1: While `rst` is high and after it falls, `lp_data`, `lp_strobe` and `lp_prime` are 0, and the control register reads back as 0.
- R2: A write with `bus_addr`=0 loads `bus_wdata` into `lp_data` at that clock edge, in both automatic and manual mode.
- R3: With control bit 0 (mode) = 0 and control bit 1 (width) = 0, a data write raises `lp_strobe` one cycle after `lp_data` updates. The pulse stays high for exactly round(CLK_HZ × 6400 ns) cycles, which is 1600 cycles at the default 250 MHz.
- R4: With control bit 0 = 0 and control bit 1 = 1, the automatic pulse lasts exactly round(CLK_HZ × 1600 ns) cycles, which is 400 cycles at 250 MHz.
- R5: A data write that arrives while an automatic pulse is high loads the new byte and restarts the count. The strobe stays high without a gap and falls the full pulse width after the restarted rise.
- R6: While `lp_strobe` is high, `lp_data` does not change unless a data write occurs.
- R7: With control bit 0 = 1 (manual), data writes fire no pulse, and `lp_strobe` follows control bit 2 one cycle after the control register changes. Switching to manual mode in the middle of a pulse ends that pulse.
- R8: `lp_prime` equals control bit 3 from the edge that writes the control register.
- R9: A read at address 0 returns, on the edge of `bus_rd`, a status byte laid out as bit7 ack, bit6 fault, bit5 select, bit4 paper-out, bit3 busy, with bits 2:0 = 0.
- R10: Each status input passes through two flops. A level applied before edge A is first returned by a read sampled at edge A+2. Reads at edges A and A+1 still return the old value.
- R11: A read at address 1 returns {4'b0, control[3:0]}. Write bits 7:4 to the control address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 1 | 0 = data/status, 1 = control |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, updated on a read edge |
| lp_data | output | 8 | Printer data lines |
| lp_strobe | output | 1 | Strobe, active high |
| lp_prime | output | 1 | Input-prime line, active high |
| st_busy | input | 1 | Printer busy (asynchronous) |
| st_paper_out | input | 1 | Paper empty (asynchronous) |
| st_select | input | 1 | Printer selected (asynchronous) |
| st_fault | input | 1 | Printer fault (asynchronous) |
| st_ack | input | 1 | Acknowledge (asynchronous) |

## Verification
Each result is due a fixed number of edges after its stimulus:
- `lp_data`, `lp_prime` and `bus_rdata` change at the edge that takes the write or read.
- `lp_strobe` changes one edge later, in both automatic and manual mode.
- A status input change shows up in a read taken two edges after the input change.

The bench drives every stimulus just after a falling edge and samples just after the following falling edge, so each check lands on the exact cycle the result is due. Pulse widths are counted sample by sample. That catches a rise that is one cycle early or late and an off-by-one in the width. The bench also reads the status byte at the two early edges to confirm the old value is still held there.

// File: rtl/pport_pkg.sv
package pport_pkg;

  // Control register layout; bit positions are decoded by the strobe logic.
  typedef struct packed {
    logic prime;    // bit 3: input-prime output
    logic man_stb;  // bit 2: strobe level in manual mode
    logic fast;     // bit 1: short automatic pulse
    logic manual;   // bit 0: manual strobe mode
  } pp_ctrl_t;

  localparam int unsigned NS_PER_S = 1_000_000_000;

  // Nearest whole number of clock cycles for a duration in ns (at least 1).
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned dur_ns);
    longint unsigned c;
    c = (clk_hz * dur_ns + NS_PER_S / 2) / NS_PER_S;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pport_pulse.sv
module pport_pulse #(
  parameter int unsigned LONG_CYC  = 1600,
  parameter int unsigned SHORT_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic fast_i,
  input  logic manual_i,
  output logic active_o
);

  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (manual_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= fast_i ? SHORT_LD : LONG_LD;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;

  // R3
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q > CNT_W'(1) && !manual_i) |=> active_q);
  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q == CNT_W'(1) && !start_i && !manual_i) |=> !active_q);
  // R7
  manual_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    manual_i |=> !active_q);
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !manual_i) |=> (active_q && cnt_q == (($past(fast_i)) ? SHORT_LD : LONG_LD)));

endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned STW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [STW-1:0] status_i,   // {ack, fault, select, paper_out, busy}
  output logic [DW-1:0]  rdata_o,
  output logic [DW-1:0]  data_o,
  output pp_ctrl_t       ctrl_o,
  output logic           start_o
);

  localparam int unsigned CW  = $bits(pp_ctrl_t);
  localparam int unsigned PAD = DW - STW;

  pp_ctrl_t      ctrl_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rdata_q;
  logic          data_wr;
  logic          ctrl_wr;

  assign data_wr = wr_i && !addr_i;
  assign ctrl_wr = wr_i && addr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= pp_ctrl_t'(wdata_i[CW-1:0]);
      if (data_wr) data_q <= wdata_i;
      if (rd_i) begin
        if (addr_i) rdata_q <= {{(DW-CW){1'b0}}, ctrl_q};
        else        rdata_q <= {status_i, {PAD{1'b0}}};
      end
    end
  end

  assign start_o = data_wr && !ctrl_q.manual;
  assign rdata_o = rdata_q;
  assign data_o  = data_q;
  assign ctrl_o  = ctrl_q;

  // R8
  prime_set_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_o.prime == $past(wdata_i[3])));
  // R9
  status_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !addr_i) |=> (rdata_o[PAD-1:0] == '0));
  // R11
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i) |=> (rdata_o[DW-1:CW] == '0));
  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (data_o == $past(wdata_i)));

endmodule

// File: rtl/pport_strobe_if.sv
module pport_strobe_if
  import pport_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned     LONG_NS  = 6400,
  parameter int unsigned     SHORT_NS = 1600,
  parameter int unsigned     DW       = 8,
  parameter int unsigned     SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] lp_data,
  output logic          lp_strobe,
  output logic          lp_prime,
  input  logic          st_busy,
  input  logic          st_paper_out,
  input  logic          st_select,
  input  logic          st_fault,
  input  logic          st_ack
);

  localparam int unsigned STW       = 5;
  localparam int unsigned LONG_CYC  = ns_to_cycles(CLK_HZ, LONG_NS);
  localparam int unsigned SHORT_CYC = ns_to_cycles(CLK_HZ, SHORT_NS);

  logic [STW-1:0] st_raw;
  logic [STW-1:0] st_sync;
  pp_ctrl_t       ctrl;
  logic           start;
  logic           pulse_on;
  logic           stb_q;

  assign st_raw = {st_ack, st_fault, st_select, st_paper_out, st_busy};

  pport_sync #(.WIDTH(STW), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (st_raw),
    .sync_o  (st_sync)
  );

  pport_regs #(.DW(DW), .STW(STW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .wdata_i  (bus_wdata),
    .status_i (st_sync),
    .rdata_o  (bus_rdata),
    .data_o   (lp_data),
    .ctrl_o   (ctrl),
    .start_o  (start)
  );

  pport_pulse #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .fast_i   (ctrl.fast),
    .manual_i (ctrl.manual),
    .active_o (pulse_on)
  );

  // Output strobe register: one cycle of data setup before the edge rises.
  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= ctrl.manual ? ctrl.man_stb : pulse_on;
  end

  assign lp_strobe = stb_q;
  assign lp_prime  = ctrl.prime;

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_strobe && !(bus_wr && !bus_addr)) |=> $stable(lp_data));
  // R7
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.manual |=> (lp_strobe == $past(ctrl.man_stb)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!lp_strobe && !lp_prime && lp_data == '0));

endmodule

// File: tb/test_pport_strobe_if.sv
module test_pport_strobe_if;

  localparam longint unsigned CLK_HZ = 250_000_000;
  localparam int LONG_N  = int'((CLK_HZ * 6400 + 500_000_000) / 1_000_000_000);
  localparam int SHORT_N = int'((CLK_HZ * 1600 + 500_000_000) / 1_000_000_000);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, lp_data;
  logic       lp_strobe, lp_prime;
  logic       st_busy = 0, st_paper_out = 0, st_select = 0, st_fault = 0, st_ack = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pport_strobe_if #(.CLK_HZ(CLK_HZ)) i_pport_strobe_if (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_data(lp_data),
    .lp_strobe(lp_strobe), .lp_prime(lp_prime), .st_busy(st_busy),
    .st_paper_out(st_paper_out), .st_select(st_select), .st_fault(st_fault),
    .st_ack(st_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks are entered just after a falling edge.
  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_status(input logic [4:0] v);
    {st_ack, st_fault, st_select, st_paper_out, st_busy} = v;
  endtask

  // Count consecutive high strobe samples from now; count data changes too.
  task automatic count_high(input logic [7:0] expd, output int n, output int moved);
    n = 0; moved = 0;
    while (lp_strobe && n < 5000) begin
      n++;
      if (lp_data != expd) moved++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int n, moved;
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    chk("R1 data", lp_data, 0);
    chk("R1 strobe", lp_strobe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 prime", lp_prime, 0);
    bus_read(1'b1, rd);
    chk("R1 ctrl", rd, 0);

    // R10 synchronizer latency: reads at edges A and A+1 old, A+2 new
    set_status(5'b10101);
    bus_read(1'b0, rd); chk("R10 edge A", rd, 0);
    bus_read(1'b0, rd); chk("R10 edge A+1", rd, 0);
    bus_read(1'b0, rd); chk("R10 edge A+2", rd, 8'(5'b10101) << 3);

    // R9 status layout, all 32 input combinations
    for (int v = 0; v < 32; v++) begin
      set_status(5'(v));
      @(negedge clk); @(negedge clk);
      bus_read(1'b0, rd);
      chk("R9 status", rd, (v << 3) & 8'hF8);
    end
    set_status(5'b0);

    // R11 control readback and ignored upper bits
    bus_write(1'b1, 8'h0A); bus_read(1'b1, rd); chk("R11 ctrl 0A", rd, 8'h0A);
    bus_write(1'b1, 8'hF6); bus_read(1'b1, rd); chk("R11 ctrl F6", rd, 8'h06);

    // R8 input prime
    bus_write(1'b1, 8'h08); chk("R8 prime on", lp_prime, 1);
    bus_write(1'b1, 8'h00); chk("R8 prime off", lp_prime, 0);

    // R3 long automatic pulse
    bus_write(1'b0, 8'h5A);
    chk("R2 data", lp_data, 8'h5A);
    chk("R3 no rise yet", lp_strobe, 0);
    @(negedge clk);
    count_high(8'h5A, n, moved);
    chk("R3 long width", n, LONG_N);
    chk("R6 data stable", moved, 0);

    // R4 short automatic pulse over walking-one data
    bus_write(1'b1, 8'h02);
    for (int b = 0; b < 8; b++) begin
      bus_write(1'b0, 8'(1 << b));
      chk("R2 data walk", lp_data, 1 << b);
      chk("R4 no rise yet", lp_strobe, 0);
      @(negedge clk);
      count_high(8'(1 << b), n, moved);
      chk("R4 short width", n, SHORT_N);
      chk("R6 data stable", moved, 0);
      @(negedge clk);
    end

    // R5 restart mid-pulse
    bus_write(1'b0, 8'hC3);
    repeat (100) @(negedge clk);
    chk("R5 high before", lp_strobe, 1);
    bus_write(1'b0, 8'h3C);
    chk("R5 data", lp_data, 8'h3C);
    count_high(8'h3C, n, moved);
    chk("R5 restarted width", n, SHORT_N + 1);

    // R7 manual mode: writes fire no pulse
    bus_write(1'b1, 8'h01);
    bus_write(1'b0, 8'h77);
    chk("R2 data manual", lp_data, 8'h77);
    n = 0;
    for (int k = 0; k < SHORT_N + 20; k++) begin
      if (lp_strobe) n++;
      @(negedge clk);
    end
    chk("R7 no pulse", n, 0);
    bus_write(1'b1, 8'h05);
    chk("R7 one-cycle lag", lp_strobe, 0);
    @(negedge clk);
    chk("R7 strobe high", lp_strobe, 1);
    bus_write(1'b1, 8'h01);
    chk("R7 lag on fall", lp_strobe, 1);
    @(negedge clk);
    chk("R7 strobe low", lp_strobe, 0);

    // R7 entering manual mode ends a running pulse
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h11);
    repeat (10) @(negedge clk);
    chk("R7 pulse running", lp_strobe, 1);
    bus_write(1'b1, 8'h01);
    @(negedge clk);
    chk("R7 pulse aborted", lp_strobe, 0);
    bus_write(1'b1, 8'h00);
    n = 0;
    for (int k = 0; k < LONG_N; k++) begin
      if (lp_strobe) n++;
      @(negedge clk);
    end
    chk("R7 no leftover", n, 0);

    finish_run();
  end

endmodule